// File: doc/BRIEF.md
# I2C Target Interface with Clock Stretching

This block is the target (slave) side of an I2C bus for a small controller-style register set. It watches the synchronised SDA and SCL lines for START and STOP conditions and shifts in the first byte after each START. That byte is compared with a programmable 7-bit own address. The all-zero general call byte can also be made to match. On a match the read/write bit decides the direction of the transfer. Data then moves one byte at a time: a receive register is read by the local host, and a transmit register is written by it.

Whenever the host has to service a byte, the block pulls SCL low and holds it there. In receive direction this happens after each byte arrives, and SCL stays low until the host reads. In transmit direction it happens before each byte goes out, and SCL stays low until the host writes. Both bus lines are open-drain, so the block's only outputs towards them are pull-low enables. Five status flags and a maskable interrupt request tell the host what has happened.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset both pull-low outputs are 0, `status_o` is 0 and `irq_o` is 0.
- R2: An address byte whose upper seven bits equal `own_addr_i` sets status bit 0 (addressed). With `ack_enable_i`=1, the block pulls SDA low for the whole acknowledge slot that follows.
- R3: An address byte that does not match leaves all status bits at 0. The block then keeps SDA and SCL released for the rest of that transfer.
- R4: The address byte 8'h00 matches only when `gc_enable_i`=1. It then sets status bit 1 (general call) as well as bit 0. With `gc_enable_i`=0 it is ignored as in R3.
- R5: With `ack_enable_i`=0 a matching address still sets status bit 0, but SDA stays released during every acknowledge slot.
- R6: In receive direction (R/W bit 0), the received byte appears on `host_rdata_o`, MSB first on the bus, and status bit 2 (byte done) is set. SCL is held low from the falling SCL edge after the eighth bit until a `host_wr_i`-independent one-cycle `host_rd_i` pulse. SCL is released on the clock after that pulse.
- R7: In transmit direction (R/W bit 1), SCL is held low after the address acknowledge and after each master ACK until `host_wr_i` supplies a byte. That byte is then sent MSB first. Status bit 2 is set in the master's acknowledge slot and cleared by the next write.
- R8: A master NACK (SDA high in the acknowledge slot of a transmitted byte) ends transmission. SDA and SCL stay released until the next START or STOP.
- R9: A STOP after an addressed transfer sets status bit 3 (stop seen) and clears bits 0, 1 and 4. The next START clears bit 3. A STOP after an unaddressed transfer leaves bit 3 at 0.
- R10: Status bit 4 (transmit direction) equals the R/W bit of the matched address byte.
- R11: `irq_o` is 1 exactly when some status bit and the same bit of `irq_mask_i` are both 1.
- R12: The SDA pull-low output changes only while the synchronised SCL is low. It changes one clock after the SCL falling edge, or later in a stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level sensed at the pad |
| sda_i | input | 1 | SDA level sensed at the pad |
| scl_drive_low_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Programmable own address |
| gc_enable_i | input | 1 | Accept general call address 8'h00 |
| ack_enable_i | input | 1 | Drive ACK on address and received bytes |
| irq_mask_i | input | 5 | Per-flag interrupt enables |
| host_wr_i | input | 1 | One-cycle write of the transmit register |
| host_wdata_i | input | 8 | Byte to transmit |
| host_rd_i | input | 1 | One-cycle read of the receive register |
| host_rdata_o | output | 8 | Last received byte |
| status_o | output | 5 | Flags: 0 addressed, 1 general call, 2 byte done, 3 stop seen, 4 transmit |
| irq_o | output | 1 | Interrupt request |

## Verification
A pad edge reaches the decision logic after two synchroniser flops plus the edge-detect register. Any resulting change on a pull-low output or status flag is therefore visible in the third clock after the pad changes. A host read releases SCL one clock after the pulse, and a host write releases it two clocks later, because the write is latched first and then loaded. The bench master holds every SCL phase for at least eight clocks and samples only at the end of a phase. Host-side results are checked two or more clocks after the pulse, so each sample falls well after the cycle in which the result is due and well before the next bus edge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int ADDR_W = 7;
   localparam int BYTE_W = 8;
   localparam int FLAG_N = 5;

   // status flag positions
   localparam int F_ADDR = 0;
   localparam int F_GC   = 1;
   localparam int F_BYTE = 2;
   localparam int F_STOP = 3;
   localparam int F_TX   = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_RX_BITS,
      ST_RX_HOLD,
      ST_RX_ACK,
      ST_TX_HOLD,
      ST_TX_BITS,
      ST_TX_ACK,
      ST_IGNORE
   } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2c_tgt_sync: WIDTH must be positive");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '1;
            else        chain[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '1;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign bus_start =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign bus_stop  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
   import i2c_tgt_pkg::*;
#(
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic [BYTE_W-1:0] addr_byte,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   output logic              hit,
   output logic              gc_hit
);

   logic own_hit;

   assign own_hit = (addr_byte[BYTE_W-1:1] == own_addr);

   if (GC_SUPPORT) begin : g_gc
      assign gc_hit = gc_en & (addr_byte == '0);
   end else begin : g_no_gc
      logic unused_gc;
      assign unused_gc = gc_en;
      assign gc_hit    = 1'b0;
   end

   assign hit = own_hit | gc_hit;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter bit GC_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   input  logic              ack_en,
   input  logic              host_wr,
   input  logic [BYTE_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [BYTE_W-1:0] host_rdata,
   output logic [FLAG_N-1:0] flags,
   output logic              scl_low,
   output logic              sda_low,
   output tgt_state_t        state_o
);

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   tgt_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] tx_reg;
   logic [BYTE_W-1:0] rx_reg;
   logic              tx_full;
   logic              rw_bit;
   logic              m_hit;
   logic              m_gc;
   logic              nack;
   logic [BYTE_W-1:0] next_shift;
   logic              cmp_hit;
   logic              cmp_gc;
   logic              tx_load;

   assign next_shift = {shreg[BYTE_W-2:0], sda_s};

   i2c_tgt_match #(.GC_SUPPORT(GC_SUPPORT)) u_match (
      .addr_byte (next_shift),
      .own_addr  (own_addr),
      .gc_en     (gc_en),
      .hit       (cmp_hit),
      .gc_hit    (cmp_gc)
   );

   assign tx_load = (state == ST_TX_HOLD) && tx_full && !bus_start && !bus_stop;

   // transmit holding register and its full bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_reg  <= '0;
         tx_full <= 1'b0;
      end else begin
         if (host_wr) tx_reg <= host_wdata;
         tx_full <= (tx_full & ~tx_load) | host_wr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         rx_reg  <= '0;
         rw_bit  <= 1'b0;
         m_hit   <= 1'b0;
         m_gc    <= 1'b0;
         nack    <= 1'b0;
         flags   <= '0;
         scl_low <= 1'b0;
         sda_low <= 1'b0;
      end else begin
         if (host_wr || host_rd) flags[F_BYTE] <= 1'b0;

         if (bus_start) begin
            state        <= ST_ADDR;
            cnt          <= '0;
            sda_low      <= 1'b0;
            scl_low      <= 1'b0;
            flags[F_ADDR] <= 1'b0;
            flags[F_GC]   <= 1'b0;
            flags[F_STOP] <= 1'b0;
            flags[F_TX]   <= 1'b0;
         end else if (bus_stop) begin
            state         <= ST_IDLE;
            sda_low       <= 1'b0;
            scl_low       <= 1'b0;
            flags[F_STOP] <= flags[F_ADDR];
            flags[F_ADDR] <= 1'b0;
            flags[F_GC]   <= 1'b0;
            flags[F_TX]   <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR: begin
                  if (scl_rise && cnt != CNT_FULL) begin
                     shreg <= next_shift;
                     cnt   <= cnt + CNT_ONE;
                     if (cnt == CNT_LAST) begin
                        m_hit  <= cmp_hit;
                        m_gc   <= cmp_gc;
                        rw_bit <= next_shift[0];
                     end
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     if (m_hit) begin
                        state         <= ST_ADDR_ACK;
                        sda_low       <= ack_en;
                        flags[F_ADDR] <= 1'b1;
                        flags[F_GC]   <= m_gc;
                        flags[F_TX]   <= rw_bit;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     cnt     <= '0;
                     if (rw_bit) begin
                        state   <= ST_TX_HOLD;
                        scl_low <= 1'b1;
                     end else begin
                        state <= ST_RX_BITS;
                     end
                  end
               end
               ST_RX_BITS: begin
                  if (scl_rise && cnt != CNT_FULL) begin
                     shreg <= next_shift;
                     cnt   <= cnt + CNT_ONE;
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     rx_reg         <= shreg;
                     flags[F_BYTE]  <= 1'b1;
                     scl_low        <= 1'b1;
                     sda_low        <= ack_en;
                     state          <= ST_RX_HOLD;
                  end
               end
               ST_RX_HOLD: begin
                  if (host_rd) begin
                     scl_low <= 1'b0;
                     state   <= ST_RX_ACK;
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     cnt     <= '0;
                     state   <= ST_RX_BITS;
                  end
               end
               ST_TX_HOLD: begin
                  if (tx_load) begin
                     shreg   <= tx_reg;
                     sda_low <= ~tx_reg[BYTE_W-1];
                     scl_low <= 1'b0;
                     cnt     <= '0;
                     state   <= ST_TX_BITS;
                  end
               end
               ST_TX_BITS: begin
                  if (scl_fall) begin
                     if (cnt == CNT_LAST) begin
                        sda_low <= 1'b0;
                        state   <= ST_TX_ACK;
                     end else begin
                        cnt     <= cnt + CNT_ONE;
                        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                        sda_low <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     nack          <= sda_s;
                     flags[F_BYTE] <= 1'b1;
                  end else if (scl_fall) begin
                     if (nack) begin
                        state <= ST_IGNORE;
                     end else begin
                        state   <= ST_TX_HOLD;
                        scl_low <= 1'b1;
                     end
                  end
               end
               ST_IDLE, ST_IGNORE: begin
                  sda_low <= 1'b0;
                  scl_low <= 1'b0;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign host_rdata = rx_reg;
   assign state_o    = state;

endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit GC_SUPPORT  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        scl_drive_low_o,
   output logic        sda_drive_low_o,
   input  logic [6:0]  own_addr_i,
   input  logic        gc_enable_i,
   input  logic        ack_enable_i,
   input  logic [4:0]  irq_mask_i,
   input  logic        host_wr_i,
   input  logic [7:0]  host_wdata_i,
   input  logic        host_rd_i,
   output logic [7:0]  host_rdata_o,
   output logic [4:0]  status_o,
   output logic        irq_o
);

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("i2c_target_stretch: SYNC_STAGES must be 2 to 4");
   end
   if (ADDR_W != 7 || BYTE_W != 8 || FLAG_N != 5) begin : g_bad_pkg
      $error("i2c_target_stretch: package widths do not fit the port list");
   end

   logic [1:0] pad_lines;
   logic [1:0] sync_lines;
   logic       scl_sync;
   logic       sda_sync;
   logic       scl_rise;
   logic       scl_fall;
   logic       bus_start;
   logic       bus_stop;
   tgt_state_t eng_state;

   assign pad_lines = {scl_i, sda_i};
   assign scl_sync  = sync_lines[1];
   assign sda_sync  = sync_lines[0];

   i2c_tgt_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_lines),
      .dout  (sync_lines)
   );

   i2c_tgt_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_sync),
      .sda_s     (sda_sync),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .bus_start (bus_start),
      .bus_stop  (bus_stop)
   );

   i2c_tgt_engine #(.GC_SUPPORT(GC_SUPPORT)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .sda_s      (sda_sync),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .bus_start  (bus_start),
      .bus_stop   (bus_stop),
      .own_addr   (own_addr_i),
      .gc_en      (gc_enable_i),
      .ack_en     (ack_enable_i),
      .host_wr    (host_wr_i),
      .host_wdata (host_wdata_i),
      .host_rd    (host_rd_i),
      .host_rdata (host_rdata_o),
      .flags      (status_o),
      .scl_low    (scl_drive_low_o),
      .sda_low    (sda_drive_low_o),
      .state_o    (eng_state)
   );

   assign irq_o = |(status_o & irq_mask_i);

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
   import i2c_tgt_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start,
   input logic              stop,
   input logic              sda_low,
   input logic              scl_low,
   input logic              host_rd,
   input logic [FLAG_N-1:0] flags,
   input tgt_state_t        state
);

   // R12
   sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_low) && !$past(start) && !$past(stop)) |-> !$past(scl_s));

   // R6
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RX_HOLD && !host_rd) |=> scl_low);

   // R6
   rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RX_HOLD && host_rd) |=> !scl_low);

   // R7
   stretch_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_low) |-> (state == ST_RX_HOLD || state == ST_TX_HOLD));

   // R8
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> (!sda_low && !scl_low));

   // R9
   stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && flags[F_ADDR]) |=> (flags[F_STOP] && !flags[F_ADDR]));

endmodule

bind i2c_target_stretch i2c_tgt_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_s   (scl_sync),
   .start   (bus_start),
   .stop    (bus_stop),
   .sda_low (sda_drive_low_o),
   .scl_low (scl_drive_low_o),
   .host_rd (host_rd_i),
   .flags   (status_o),
   .state   (eng_state)
);

// File: tb/tb_i2c_target_stretch.sv
`timescale 1ns/1ps
module tb_i2c_target_stretch;

   localparam int Q = 8;
   localparam logic [6:0] OWN = 7'h52;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       scl_drive_low, sda_drive_low;
   logic [6:0] own_addr = OWN;
   logic       gc_en = 1'b0;
   logic       ack_en = 1'b1;
   logic [4:0] irq_mask = 5'h1F;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       host_rd = 1'b0;
   logic [7:0] host_rdata;
   logic [4:0] status;
   logic       irq;
   wire        scl_bus = scl_m & ~scl_drive_low;
   wire        sda_bus = sda_m & ~sda_drive_low;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   bit mon_en = 1'b0;
   bit seen_sda = 1'b0;
   bit seen_scl = 1'b0;
   int r12_viol = 0;
   logic sda_prev = 1'b0;

   always #2.5 clk = ~clk;

   i2c_target_stretch dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl_bus),
      .sda_i           (sda_bus),
      .scl_drive_low_o (scl_drive_low),
      .sda_drive_low_o (sda_drive_low),
      .own_addr_i      (own_addr),
      .gc_enable_i     (gc_en),
      .ack_enable_i    (ack_en),
      .irq_mask_i      (irq_mask),
      .host_wr_i       (host_wr),
      .host_wdata_i    (host_wdata),
      .host_rd_i       (host_rd),
      .host_rdata_o    (host_rdata),
      .status_o        (status),
      .irq_o           (irq)
   );

   always @(negedge clk) begin
      if (mon_en) begin
         if (sda_drive_low) seen_sda = 1'b1;
         if (scl_drive_low) seen_scl = 1'b1;
      end
      // R12: SDA pull-low only changes while the bus clock is low
      if (rst_n && sda_drive_low != sda_prev && scl_bus) r12_viol++;
      sda_prev = sda_drive_low;
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic scl_up();
      scl_m = 1'b1;
      while (!scl_bus) @(negedge clk);
      tick(Q);
   endtask

   task automatic bit_out(input bit b);
      sda_m = b; tick(Q); scl_up(); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bit_in(output bit b);
      sda_m = 1'b1; tick(Q); scl_up(); b = sda_bus; scl_m = 1'b0; tick(Q);
   endtask

   task automatic start_c();
      sda_m = 1'b1; tick(Q); scl_up(); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic stop_c();
      sda_m = 1'b0; tick(Q); scl_up(); sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) bit_out(v[i]);
   endtask

   task automatic recv_byte(output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin bit_in(b); v[i] = b; end
   endtask

   task automatic ack_slot(output bit acked);
      bit b;
      bit_in(b);
      acked = !b;
   endtask

   task automatic do_read();
      host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
   endtask

   task automatic do_write(input logic [7:0] v);
      host_wdata = v; host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit ackd;
      logic [7:0] got;
      logic [7:0] pats [6];
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5;
      pats[3] = 8'h5A; pats[4] = 8'h01; pats[5] = 8'h80;

      tick(4);
      // R1: reset state
      check("R1 scl pull", scl_drive_low, 0);
      check("R1 sda pull", sda_drive_low, 0);
      check("R1 status", status, 0);
      check("R1 irq", irq, 0);
      rst_n = 1'b1;
      tick(4);

      // ---- receive transfer ----
      start_c();
      send_byte({OWN, 1'b0});
      ack_slot(ackd);
      check("R2 address ack", ackd, 1);
      check("R2 addressed flag", status[0], 1);
      check("R10 direction rx", status[4], 0);
      for (int p = 0; p < 6; p++) begin
         send_byte(pats[p]);
         tick(2 * Q);
         check("R6 stretch after byte", scl_drive_low, 1);
         tick(30);
         check("R6 stretch held", scl_drive_low, 1);
         check("R6 byte done flag", status[2], 1);
         check("R6 received byte", host_rdata, pats[p]);
         if (p == 0) begin
            // R11: flags at this point are bits 0 and 2
            check("R11 irq all enabled", irq, 1);
            irq_mask = 5'b11010; tick(1);
            check("R11 irq masked", irq, 0);
            irq_mask = 5'b00100; tick(1);
            check("R11 irq byte only", irq, 1);
            irq_mask = 5'h1F;
         end
         do_read();
         tick(2);
         check("R6 release after read", scl_drive_low, 0);
         check("R6 flag cleared by read", status[2], 0);
         ack_slot(ackd);
         check("R6 data ack", ackd, 1);
      end
      stop_c();
      tick(4);
      check("R9 stop flag", status[3], 1);
      check("R9 addressed cleared", status[0], 0);
      start_c();
      check("R9 start clears stop", status[3], 0);
      stop_c();
      tick(4);
      check("R9 no stop flag unaddressed", status[3], 0);

      // ---- address mismatch sweep ----
      for (int i = 0; i < 7; i++) begin
         start_c();
         send_byte({OWN ^ 7'(1 << i), 1'b0});
         seen_sda = 1'b0; seen_scl = 1'b0; mon_en = 1'b1;
         ack_slot(ackd);
         send_byte(8'h3C);
         bit_out(1'b1);
         mon_en = 1'b0;
         check("R3 no ack", ackd, 0);
         check("R3 sda untouched", seen_sda, 0);
         check("R3 scl untouched", seen_scl, 0);
         check("R3 flags clear", status, 0);
         stop_c();
      end

      // ---- general call ----
      gc_en = 1'b0;
      start_c(); send_byte(8'h00); ack_slot(ackd);
      check("R4 gc disabled no ack", ackd, 0);
      check("R4 gc disabled flags", status, 0);
      stop_c();
      gc_en = 1'b1;
      start_c(); send_byte(8'h00); ack_slot(ackd);
      check("R4 gc ack", ackd, 1);
      check("R4 gc flags", status[1:0], 3);
      stop_c();
      gc_en = 1'b0;

      // ---- acknowledge disabled ----
      ack_en = 1'b0;
      start_c(); send_byte({OWN, 1'b0}); ack_slot(ackd);
      check("R5 no ack when disabled", ackd, 0);
      check("R5 still addressed", status[0], 1);
      send_byte(8'h77);
      tick(2 * Q);
      do_read();
      ack_slot(ackd);
      check("R5 no data ack", ackd, 0);
      stop_c();
      ack_en = 1'b1;

      // ---- transmit transfer ----
      start_c();
      send_byte({OWN, 1'b1});
      ack_slot(ackd);
      check("R2 read address ack", ackd, 1);
      check("R10 direction tx", status[4], 1);
      tick(2 * Q);
      check("R7 stretch before first byte", scl_drive_low, 1);
      tick(30);
      check("R7 stretch held", scl_drive_low, 1);
      for (int p = 0; p < 6; p++) begin
         do_write(pats[p] ^ 8'h3C);
         tick(3);
         check("R7 release after write", scl_drive_low, 0);
         recv_byte(got);
         check("R7 transmitted byte", got, pats[p] ^ 8'h3C);
         if (p < 5) begin
            bit_out(1'b0);
            tick(Q);
            check("R7 stretch after ack", scl_drive_low, 1);
            check("R7 byte done flag", status[2], 1);
         end else begin
            bit_out(1'b1);
            tick(Q);
            check("R8 scl released after nack", scl_drive_low, 0);
            check("R8 sda released after nack", sda_drive_low, 0);
         end
      end
      seen_sda = 1'b0; seen_scl = 1'b0; mon_en = 1'b1;
      for (int k = 0; k < 9; k++) bit_in(ackd);
      mon_en = 1'b0;
      check("R8 quiet sda", seen_sda, 0);
      check("R8 quiet scl", seen_scl, 0);
      stop_c();
      tick(4);
      check("R9 stop after tx", status[3], 1);
      check("R9 tx flag cleared", status[4], 0);

      check("R12 sda changes with scl low", r12_viol, 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule